// File: doc/BRIEF.md
# Dithered Cascaded Accumulator Noise Source

The block is a pseudo-random bit source built from a chain of modulo-2^W accumulators in the shape of a multi-stage sigma-delta modulator, like those used for fractional frequency synthesis. In each cycle every stage adds an input word to the residue, or quantization error, that it held in the previous cycle. It then produces an overflow bit and a new residue. The first stage accumulates a constant word `x_i`. Each later stage accumulates the residue of the stage in front of it. Each stage except the last also folds in the overflow bit that the stage behind it produced in the previous cycle, so the chain is self-recursive.

A plain chain of this kind falls into short periodic patterns. To prevent this, the residue of the first stage is multiplied by a coefficient `coef_i` and added back into that stage, but only in cycles where a free-running 16-bit maximal-length LFSR presents a 1 on its dither bit. The registered overflow bits of all stages form the output word. With the default parameters there are nine stages of eight bits each, and the modulus is fixed at 256.

Top module: `sdprng_top`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `carry_o` is all zeros. Reset clears every residue and overflow bit and loads the LFSR with 16'hACE1.
- R2: Stage 0 forms sum0 = x_i + res0 + ovf1 + dith. Here res0 is its own residue from the previous cycle, ovf1 is stage 1's overflow from the previous cycle, and dith is the dither term from R6.
- R3: For every stage, the new residue is the sum modulo 256, which is the low 8 bits of the sum. The new overflow bit is 1 exactly when the sum is at least 256.
- R4: Stage k with k ≥ 1 takes as its input the residue that stage k-1 held in the previous cycle. For example, with x_i held at 200 from reset, `carry_o[1]` is first 1 in the third cycle.
- R5: Stage k with k < 8 adds the overflow bit that stage k+1 produced in the previous cycle. Stage 8 adds no feedback term.
- R6: dith = (coef_i × res0) mod 256 when the dither bit d is 1, and dith = 0 when d is 0. The dither bit d is bit 15 of the LFSR. With coef_i = 0 the dither term is always 0.
- R7: The LFSR shifts left once every cycle after reset. The new bit 0 is the XOR of bits 15, 13, 12 and 10, which gives the polynomial x^16+x^14+x^13+x^11+1. The register is never zero.
- R8: With x_i = 0 and coef_i = 0 from reset onward, `carry_o` stays all zeros.
- R9: `carry_o[k]` is stage k's overflow bit, registered. It changes one clock edge after the state it was computed from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 8 | Constant word accumulated by stage 0 |
| coef_i | input | 8 | Dither coefficient that scales the stage 0 residue |
| carry_o | output | 9 | Registered overflow bits, bit k from stage k |

## Verification
Some properties hold from one cycle to the next and are checked every cycle: the LFSR shifts and never reaches zero, stage 0's overflow follows from its inputs when dither is off, the last stage's overflow follows from the residues of the stages in front of it, and the chain stays silent when it is at rest with zero inputs. Other behaviour only shows over many cycles, and only the bench scenarios can show it. This covers how the residues ripple down the chain, how the LFSR sequence and the dither combine to form the output pattern, and whether the same sequence replays exactly after a reset taken in the middle of a run. The bench checks these against a cycle-exact model across directed and random inputs.

// File: rtl/sdprng_pkg.sv
package sdprng_pkg;

    // Default geometry of the accumulator chain
    localparam int unsigned DEF_STAGES  = 9;
    localparam int unsigned DEF_ACC_W   = 8;
    localparam int unsigned DEF_LFSR_W  = 16;
    localparam logic [15:0] DEF_TAPS    = 16'hB400;
    localparam logic [15:0] DEF_SEED    = 16'hACE1;

    // Extra sum bits: three full-width terms plus one bit never exceed 2 bits of growth
    localparam int unsigned SUM_GROWTH  = 2;

endpackage

// File: rtl/sdprng_lfsr.sv
module sdprng_lfsr #(
    parameter int unsigned       LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hB400
) (
    input  logic [LFSR_W-1:0] state_i,
    output logic [LFSR_W-1:0] next_o,
    output logic              dith_bit_o
);
    logic fb;

    always_comb begin
        fb         = ^(state_i & TAPS);
        next_o     = {state_i[LFSR_W-2:0], fb};
        dith_bit_o = state_i[LFSR_W-1];
    end
endmodule

// File: rtl/sdprng_dither.sv
module sdprng_dither #(
    parameter int unsigned ACC_W = 8
) (
    input  logic             en_i,
    input  logic [ACC_W-1:0] coef_i,
    input  logic [ACC_W-1:0] res_i,
    output logic [ACC_W-1:0] dith_o
);
    localparam int unsigned PROD_W = 2 * ACC_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod   = PROD_W'(coef_i) * PROD_W'(res_i);
        dith_o = en_i ? prod[ACC_W-1:0] : '0;
    end
endmodule

// File: rtl/sdprng_stage.sv
module sdprng_stage #(
    parameter int unsigned ACC_W  = 8,
    parameter int unsigned GROWTH = 2
) (
    input  logic             in_i,
    input  logic [ACC_W-1:0] add_i,
    input  logic [ACC_W-1:0] res_q_i,
    input  logic [ACC_W-1:0] dith_i,
    output logic [ACC_W-1:0] res_d_o,
    output logic             ovf_d_o
);
    localparam int unsigned SUM_W = ACC_W + GROWTH;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(add_i) + SUM_W'(res_q_i) + SUM_W'(dith_i) + SUM_W'(in_i);
        res_d_o = sum[ACC_W-1:0];
        ovf_d_o = |sum[SUM_W-1:ACC_W];
    end
endmodule

// File: rtl/sdprng_top.sv
module sdprng_top
    import sdprng_pkg::*;
#(
    parameter int unsigned          NUM_STAGES = DEF_STAGES,
    parameter int unsigned          ACC_W      = DEF_ACC_W,
    parameter int unsigned          LFSR_W     = DEF_LFSR_W,
    parameter logic [LFSR_W-1:0]    LFSR_TAPS  = DEF_TAPS,
    parameter logic [LFSR_W-1:0]    LFSR_SEED  = DEF_SEED
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [ACC_W-1:0]      x_i,
    input  logic [ACC_W-1:0]      coef_i,
    output logic [NUM_STAGES-1:0] carry_o
);
    localparam int unsigned LAST = NUM_STAGES - 1;

    typedef struct packed {
        logic [NUM_STAGES-1:0][ACC_W-1:0] res;
        logic [NUM_STAGES-1:0]            ovf;
        logic [LFSR_W-1:0]                lfsr;
    } state_t;

    localparam state_t RESET_ST = '{res: '0, ovf: '0, lfsr: LFSR_SEED};

    state_t st_d, st_q;

    logic [LFSR_W-1:0]                lfsr_nx;
    logic                             dith_bit;
    logic [ACC_W-1:0]                 dith_val;
    logic [NUM_STAGES-1:0][ACC_W-1:0] res_nx;
    logic [NUM_STAGES-1:0]            ovf_nx;

    // Flattened views for the bound checker
    logic [NUM_STAGES*ACC_W-1:0]      res_flat;
    logic [LFSR_W-1:0]                lfsr_state;

    sdprng_lfsr #(
        .LFSR_W (LFSR_W),
        .TAPS   (LFSR_TAPS)
    ) i_lfsr (
        .state_i    (st_q.lfsr),
        .next_o     (lfsr_nx),
        .dith_bit_o (dith_bit)
    );

    sdprng_dither #(
        .ACC_W (ACC_W)
    ) i_dither (
        .en_i   (dith_bit),
        .coef_i (coef_i),
        .res_i  (st_q.res[0]),
        .dith_o (dith_val)
    );

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        logic [ACC_W-1:0] add_w;
        logic [ACC_W-1:0] dith_w;
        logic             fb_w;

        if (k == 0) begin : g_head
            assign add_w  = x_i;
            assign dith_w = dith_val;
        end else begin : g_body
            assign add_w  = st_q.res[k-1];
            assign dith_w = '0;
        end

        if (k < LAST) begin : g_fb
            assign fb_w = st_q.ovf[k+1];
        end else begin : g_tail
            assign fb_w = 1'b0;
        end

        sdprng_stage #(
            .ACC_W  (ACC_W),
            .GROWTH (SUM_GROWTH)
        ) i_stage (
            .in_i    (fb_w),
            .add_i   (add_w),
            .res_q_i (st_q.res[k]),
            .dith_i  (dith_w),
            .res_d_o (res_nx[k]),
            .ovf_d_o (ovf_nx[k])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.res  = res_nx;
        st_d.ovf  = ovf_nx;
        st_d.lfsr = lfsr_nx;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry_o    = st_q.ovf;
    assign res_flat   = st_q.res;
    assign lfsr_state = st_q.lfsr;

endmodule

// File: rtl/sdprng_chk.sv
module sdprng_chk #(
    parameter int unsigned NUM_STAGES = 9,
    parameter int unsigned ACC_W      = 8,
    parameter int unsigned LFSR_W     = 16
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic [ACC_W-1:0]            x_i,
    input logic [ACC_W-1:0]            coef_i,
    input logic [NUM_STAGES-1:0]       carry_o,
    input logic [NUM_STAGES*ACC_W-1:0] res_flat,
    input logic [LFSR_W-1:0]           lfsr_state
);
    localparam int unsigned SW   = ACC_W + 2;
    localparam int unsigned LAST = NUM_STAGES - 1;

    logic [ACC_W-1:0] res0, res_pen, res_last;
    logic [SW-1:0]    head_sum, tail_sum;

    always_comb begin
        res0     = res_flat[ACC_W-1:0];
        res_pen  = res_flat[(LAST)*ACC_W-1 -: ACC_W];
        res_last = res_flat[NUM_STAGES*ACC_W-1 -: ACC_W];
        head_sum = SW'(x_i) + SW'(res0) + SW'(carry_o[1]);
        tail_sum = SW'(res_pen) + SW'(res_last);
    end

    assert_lfsr_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_state != '0);

    assert_lfsr_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> lfsr_state[LFSR_W-1:1] == $past(lfsr_state[LFSR_W-2:0]));

    // R2 and R3: without dither, stage 0 overflows exactly when its sum reaches the modulus
    assert_head_ovf_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coef_i == '0 |=> carry_o[0] == $past(head_sum >= SW'(1 << ACC_W)));

    // R4 and R5: last stage takes the previous residue of its neighbour, no feedback term
    assert_tail_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> carry_o[LAST] == $past(tail_sum >= SW'(1 << ACC_W)));

    assert_quiet_chain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_i == '0 && coef_i == '0 && res_flat == '0 && carry_o == '0) |=> carry_o == '0);

endmodule

bind sdprng_top sdprng_chk #(
    .NUM_STAGES (NUM_STAGES),
    .ACC_W      (ACC_W),
    .LFSR_W     (LFSR_W)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .x_i        (x_i),
    .coef_i     (coef_i),
    .carry_o    (carry_o),
    .res_flat   (res_flat),
    .lfsr_state (lfsr_state)
);

// File: tb/test_sdprng_top.sv
module test_sdprng_top;
    localparam int N = 9;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [7:0]   x_i = '0;
    logic [7:0]   coef_i = '0;
    logic [N-1:0] carry_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference model state
    logic [7:0]   m_res [N];
    logic [N-1:0] m_ovf;
    logic [15:0]  m_lfsr;

    sdprng_top i_sdprng_top (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .x_i     (x_i),
        .coef_i  (coef_i),
        .carry_o (carry_o)
    );

    always #4 clk_i = ~clk_i;

    function automatic void model_reset();
        for (int k = 0; k < N; k++) m_res[k] = '0;
        m_ovf  = '0;
        m_lfsr = 16'hACE1;
    endfunction

    function automatic void model_step(logic [7:0] x, logic [7:0] c);
        logic [7:0]   nres [N];
        logic [N-1:0] novf;
        logic [15:0]  prod;
        int           s;
        int           dith;
        prod = 16'(c) * 16'(m_res[0]);
        dith = m_lfsr[15] ? int'(prod[7:0]) : 0;
        for (int k = 0; k < N; k++) begin
            s = int'(m_res[k]);
            s += (k == 0) ? int'(x) : int'(m_res[k-1]);
            if (k < N - 1) s += int'(m_ovf[k+1]);
            if (k == 0) s += dith;
            nres[k] = 8'(s % 256);
            novf[k] = (s >= 256);
        end
        for (int k = 0; k < N; k++) m_res[k] = nres[k];
        m_ovf  = novf;
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    endfunction

    task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: carry_o=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        model_reset();
        repeat (3) @(negedge clk_i);
        check("R1 during reset", carry_o, '0);
        rst_ni = 1'b1;
    endtask

    // Drive at negedge, let one edge pass, compare at the following negedge
    task automatic step(string tag, logic [7:0] x, logic [7:0] c);
        x_i    = x;
        coef_i = c;
        @(posedge clk_i);
        model_step(x, c);
        @(negedge clk_i);
        check(tag, carry_o, m_ovf);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            report();
        end
    end

    initial begin
        logic [N-1:0] first_run [64];
        logic [7:0]   xs [64];
        logic [7:0]   cs [64];
        void'($urandom(32'd4242));
        @(negedge clk_i);
        do_reset();

        // R1: first cycle after release still silent
        step("R1 first cycle", 8'd0, 8'd0);

        // R8: zero inputs keep chain silent
        for (int i = 0; i < 20; i++) step("R8 quiet", 8'd0, 8'd0);

        // R9, R4: directed ripple with x=200 from reset
        do_reset();
        x_i = 8'd200; coef_i = 8'd0;
        @(posedge clk_i); model_step(8'd200, 8'd0); @(negedge clk_i);
        check("R9 no carry after edge 1", carry_o, N'(0));
        @(posedge clk_i); model_step(8'd200, 8'd0); @(negedge clk_i);
        check("R9 stage0 carry after edge 2", carry_o, N'(1));
        @(posedge clk_i); model_step(8'd200, 8'd0); @(negedge clk_i);
        check("R4 stage1 carry after edge 3", carry_o & N'(3), N'(3));
        for (int i = 0; i < 30; i++) step("R4 R5 ripple", 8'd200, 8'd0);

        // R3: largest constant, full-scale wrap
        do_reset();
        for (int i = 0; i < 40; i++) step("R3 x=255", 8'd255, 8'd0);

        // R2 R5: small constant, feedback dominates
        do_reset();
        for (int i = 0; i < 60; i++) step("R2 R5 x=1", 8'd1, 8'd0);

        // R6: maximum coefficient, dither active on LFSR bit
        do_reset();
        for (int i = 0; i < 60; i++) step("R6 coef=255", 8'd77, 8'd255);

        // R6 R7: random inputs, recorded for replay
        do_reset();
        for (int i = 0; i < 64; i++) begin
            xs[i] = 8'($urandom);
            cs[i] = 8'($urandom);
            step("R6 R7 random", xs[i], cs[i]);
            first_run[i] = carry_o;
        end

        // R1 R7: mid-run reset replays the identical sequence
        for (int i = 0; i < 5; i++) step("R7 continue", 8'($urandom), 8'($urandom));
        do_reset();
        for (int i = 0; i < 64; i++) begin
            step("R7 replay model", xs[i], cs[i]);
            check("R1 R7 replay equals first run", carry_o, first_run[i]);
        end

        // Long random mix with held values
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) begin
                xs[0] = 8'($urandom);
                cs[0] = (i % 100 == 0) ? 8'd0 : 8'($urandom);
            end
            step("R2 R6 long run", xs[0], cs[0]);
        end

        done = 1;
        report();
    end
endmodule